// File: doc/BRIEF.md
# Clock Synchronizer Mode Controller

This block is the supervisory state machine of a telecom clock synchronizer. It decides whether the synchronizer free-runs, tracks a reference (Normal), holds its last frequency by request (Holdover), holds because the tracked reference went bad (Auto Holdover), or performs a short forced hold to realign its output phase (Realign). The phase-locked loops themselves live elsewhere. This controller only sees their status: one fault flag per reference tracker and a lock-detected flag from the core loop.

Software or pins pick the wanted mode with a two-bit request and pick one of two references. When the tracked reference fails, the controller drops its lock indication and holds. It returns to Normal either on its own, after the reference has stayed good for a set time, or when a manual release bit changes level. A long, active-low realign request makes the controller hold for a short fixed time while the lock indication stays high. All timings are counted in system clock cycles and derived from parameters.

Top module: `clk_sync_mode_ctl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `mode_out` is FreeRun and `lock` and `ref_active` are 0. The mode encoding is: 0 FreeRun, 1 Normal, 2 Holdover, 3 Auto Holdover, 4 Realign.
- R2: A filtered mode request of 2'b10 moves the controller to FreeRun from any mode on the next cycle.
- R3: Mode requests 2'b00 and 2'b11 ask for Normal and 2'b01 asks for Holdover. A request takes effect only after it has been sampled equal on two consecutive cycles, so a request that lasts a single cycle is ignored.
- R4: Entering Normal from FreeRun, Holdover or Auto Holdover clears `lock`. `lock` rises only after `loop_locked` has been sampled high on SETTLE_CYC consecutive cycles in Normal. A low sample restarts the count.
- R5: In Normal, a fault on the selected reference (`pri_fault` when `ref_active`=0, `sec_fault` when `ref_active`=1) moves the controller to Auto Holdover, and `lock` falls on the same edge. A fault on the other reference has no effect.
- R6: With `auto_ret_en`=1, Auto Holdover returns to Normal after the selected reference has been fault-free for GOOD_CYC consecutive cycles.
- R7: With `auto_ret_en`=0, Auto Holdover is left for Normal only when `man_release` changes level, in either direction.
- R8: In Normal, taking `realign_req_n` low for at least REQ_LOW_US microseconds of clock cycles and then high enters Realign for the realign hold time (REALIGN_NS, rounded up to whole cycles). The controller then goes back to Normal, and `lock` stays high throughout.
- R9: A realign request with a shorter low time is ignored, and so is a qualified request that arrives outside Normal.
- R10: `ref_active` follows `ref_pick` one cycle later. Switching references in Normal while both are fault-free leaves the mode at Normal and `lock` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 2 | Requested mode: 00/11 Normal, 01 Holdover, 10 FreeRun |
| ref_pick | input | 1 | Reference choice: 0 primary, 1 secondary |
| pri_fault | input | 1 | Primary tracker reports a bad reference |
| sec_fault | input | 1 | Secondary tracker reports a bad reference |
| realign_req_n | input | 1 | Active-low realign request |
| auto_ret_en | input | 1 | 1: leave Auto Holdover automatically |
| man_release | input | 1 | Manual release; a level change releases Auto Holdover |
| loop_locked | input | 1 | Lock-detected flag from the core loop |
| mode_out | output | 3 | Current mode |
| lock | output | 1 | Lock status |
| ref_active | output | 1 | Reference currently selected |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- A one-cycle glitch to the FreeRun code while locked. A request filter that is missing or too short would drop the controller into FreeRun.
- A `loop_locked` dropout partway through the settle count. A counter that does not restart would raise `lock` early.
- Realign requests that are too short or that arrive in Holdover. A qualifier that ignores the low time, or an FSM that acts on the request in any mode, would enter Realign wrongly. For a valid request, the bench checks that `lock` stays high across the hold and that the hold ends on time.
- Faults on the unselected reference, and release inputs held static while automatic return is off. A design that watches the wrong tracker, or that releases without a toggle, would leave or enter Auto Holdover at the wrong time.

// File: rtl/csm_pkg.sv
package csm_pkg;
  typedef enum logic [2:0] {
    MODE_FREE    = 3'd0,
    MODE_NORMAL  = 3'd1,
    MODE_HOLD    = 3'd2,
    MODE_AUTO_HO = 3'd3,
    MODE_REALIGN = 3'd4
  } mode_e;

  localparam logic [1:0] REQ_FREE = 2'b10;
  localparam logic [1:0] REQ_HOLD = 2'b01;
endpackage

// File: rtl/csm_req_filter.sv
module csm_req_filter #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] req_in,
  output logic [W-1:0] req_eff
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1      <= RST_VAL;
      s2      <= RST_VAL;
      req_eff <= RST_VAL;
    end else begin
      s1 <= req_in;
      s2 <= s1;
      if (s1 == s2) req_eff <= s2;
    end
  end

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
    !$stable(req_eff) |-> ($past(s1) == $past(s2))); // R3
endmodule

// File: rtl/csm_run_count.sv
module csm_run_count #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic hit
);
  localparam int CW = (N < 2) ? 1 : $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign hit = en && (cnt == LAST);
endmodule

// File: rtl/csm_realign_qual.sv
module csm_realign_qual #(
  parameter int LOW_CYC = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic req_n,
  output logic go
);
  localparam int CW = $clog2(LOW_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(LOW_CYC);
  logic [CW-1:0] low_cnt;
  logic          req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      req_q   <= 1'b1;
      go      <= 1'b0;
    end else begin
      req_q <= req_n;
      go    <= req_n && !req_q && (low_cnt == FULL);
      if (req_n) low_cnt <= '0;
      else if (low_cnt != FULL) low_cnt <= low_cnt + 1'b1;
    end
  end

  AST_GO_PULSE: assert property (@(posedge clk) disable iff (rst)
    go |=> !go); // R8
endmodule

// File: rtl/clk_sync_mode_ctl.sv
module clk_sync_mode_ctl #(
  parameter int CLK_MHZ    = 200,
  parameter int REALIGN_NS = 200,
  parameter int REQ_LOW_US = 250,
  parameter int SETTLE_CYC = 64,
  parameter int GOOD_CYC   = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_req,
  input  logic       ref_pick,
  input  logic       pri_fault,
  input  logic       sec_fault,
  input  logic       realign_req_n,
  input  logic       auto_ret_en,
  input  logic       man_release,
  input  logic       loop_locked,
  output logic [2:0] mode_out,
  output logic       lock,
  output logic       ref_active
);
  import csm_pkg::*;

  localparam int HOLD_CYC = (CLK_MHZ * REALIGN_NS + 999) / 1000;
  localparam int LOW_CYC  = CLK_MHZ * REQ_LOW_US;

  mode_e      mode_q, mode_d;
  logic [1:0] req_eff;
  logic       rl_go, settle_hit, good_hit, hold_hit;
  logic       man_q, man_tog, sel_fault, lock_d;
  logic       want_hold, want_free;

  csm_req_filter #(.W(2), .RST_VAL(REQ_FREE)) u_filt (
    .clk(clk), .rst(rst), .req_in(mode_req), .req_eff(req_eff));

  csm_realign_qual #(.LOW_CYC(LOW_CYC)) u_rq (
    .clk(clk), .rst(rst), .req_n(realign_req_n), .go(rl_go));

  csm_run_count #(.N(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst),
    .en((mode_q == MODE_NORMAL) && !lock && loop_locked), .hit(settle_hit));

  csm_run_count #(.N(GOOD_CYC)) u_good (
    .clk(clk), .rst(rst),
    .en((mode_q == MODE_AUTO_HO) && auto_ret_en && !sel_fault), .hit(good_hit));

  csm_run_count #(.N(HOLD_CYC)) u_hold (
    .clk(clk), .rst(rst), .en(mode_q == MODE_REALIGN), .hit(hold_hit));

  assign sel_fault = ref_active ? sec_fault : pri_fault;
  assign man_tog   = man_release ^ man_q;
  assign want_free = (req_eff == REQ_FREE);
  assign want_hold = (req_eff == REQ_HOLD);

  always_comb begin
    mode_d = mode_q;
    if (want_free) mode_d = MODE_FREE;
    else begin
      case (mode_q)
        MODE_FREE, MODE_HOLD: mode_d = want_hold ? MODE_HOLD : MODE_NORMAL;
        MODE_NORMAL: begin
          if (want_hold)      mode_d = MODE_HOLD;
          else if (sel_fault) mode_d = MODE_AUTO_HO;
          else if (rl_go)     mode_d = MODE_REALIGN;
        end
        MODE_AUTO_HO: begin
          if (want_hold) mode_d = MODE_HOLD;
          else if (auto_ret_en ? good_hit : man_tog) mode_d = MODE_NORMAL;
        end
        MODE_REALIGN: begin
          if (want_hold)      mode_d = MODE_HOLD;
          else if (sel_fault) mode_d = MODE_AUTO_HO;
          else if (hold_hit)  mode_d = MODE_NORMAL;
        end
        default: mode_d = MODE_FREE;
      endcase
    end
  end

  always_comb begin
    lock_d = lock;
    if (mode_d != MODE_NORMAL && mode_d != MODE_REALIGN) lock_d = 1'b0;
    else if (mode_q != MODE_NORMAL && mode_q != MODE_REALIGN) lock_d = 1'b0;
    else if (settle_hit) lock_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MODE_FREE;
      lock       <= 1'b0;
      ref_active <= 1'b0;
      man_q      <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      lock       <= lock_d;
      ref_active <= ref_pick;
      man_q      <= man_release;
    end
  end

  assign mode_out = mode_q;

  AST_RST_FREE: assert property (@(posedge clk)
    rst |=> (mode_q == MODE_FREE && !lock)); // R1
  AST_FORCE_FREE: assert property (@(posedge clk) disable iff (rst)
    want_free |=> (mode_q == MODE_FREE)); // R2
  AST_SETTLE_GATE: assert property (@(posedge clk) disable iff (rst)
    $rose(lock) |-> ($past(mode_q) == MODE_NORMAL && $past(loop_locked))); // R4
  AST_AHO_NOLOCK: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_AUTO_HO) |-> !lock); // R5
  AST_MAN_GATE: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_AUTO_HO && !auto_ret_en && !man_tog && !want_free && !want_hold)
      |=> (mode_q == MODE_AUTO_HO)); // R7
  AST_REALIGN_LOCK: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_REALIGN && lock && !want_free && !want_hold && !sel_fault)
      |=> lock); // R8
  AST_REALIGN_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_REALIGN && $past(mode_q) != MODE_REALIGN)
      |-> ($past(mode_q) == MODE_NORMAL)); // R9
endmodule

// File: tb/clk_sync_mode_ctl_bench.sv
`timescale 1ns/1ps
module clk_sync_mode_ctl_bench;
  localparam int SETTLE = 8;
  localparam int GOOD   = 12;
  localparam int HOLD   = 40;   // 200 MHz * 200 ns
  localparam int LOWC   = 200;  // 200 MHz * 1 us

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode_req = 2'b10;
  logic ref_pick = 0, pri_fault = 0, sec_fault = 0, realign_req_n = 1;
  logic auto_ret_en = 0, man_release = 0, loop_locked = 0;
  logic [2:0] mode_out;
  logic lock, ref_active;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  clk_sync_mode_ctl #(.CLK_MHZ(200), .REALIGN_NS(200), .REQ_LOW_US(1),
    .SETTLE_CYC(SETTLE), .GOOD_CYC(GOOD)) u_clk_sync_mode_ctl (
    .clk(clk), .rst(rst), .mode_req(mode_req), .ref_pick(ref_pick),
    .pri_fault(pri_fault), .sec_fault(sec_fault), .realign_req_n(realign_req_n),
    .auto_ret_en(auto_ret_en), .man_release(man_release), .loop_locked(loop_locked),
    .mode_out(mode_out), .lock(lock), .ref_active(ref_active));

  function automatic int exp_mode(input logic [1:0] r);
    if (r == 2'b10) return 0;
    if (r == 2'b01) return 2;
    return 1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ck_mode(input string req, input int exp);
    chk(int'(mode_out) == exp, req, "mode", int'(mode_out), exp);
  endtask

  task automatic ck_lock(input string req, input int exp);
    chk(int'(lock) == exp, req, "lock", int'(lock), exp);
  endtask

  task automatic realign_pulse(input int low);
    realign_req_n = 0; cyc(low); realign_req_n = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    cyc(3);
    ck_mode("R1", 0); ck_lock("R1", 0);
    chk(ref_active == 0, "R1", "ref_active", int'(ref_active), 0);
    rst = 0; cyc(1);
    ck_mode("R1", 0);

    // R4: enter Normal with loop unlocked, then a dropout mid-count
    mode_req = 2'b00; cyc(6);
    ck_mode("R3", 1); ck_lock("R4", 0);
    loop_locked = 1; cyc(SETTLE - 2); loop_locked = 0; cyc(1); loop_locked = 1;
    cyc(SETTLE - 2); ck_lock("R4", 0);
    cyc(4); ck_lock("R4", 1);

    // R3: single-cycle glitch to the FreeRun code is ignored
    mode_req = 2'b10; cyc(1); mode_req = 2'b00; cyc(6);
    ck_mode("R3", 1); ck_lock("R3", 1);

    // R10: reference switch while Normal
    ref_pick = 1; cyc(1);
    chk(ref_active == 1, "R10", "ref_active", int'(ref_active), 1);
    cyc(3); ck_mode("R10", 1); ck_lock("R10", 1);

    // R5: fault on the unselected reference, then on the selected one
    pri_fault = 1; cyc(4); ck_mode("R5", 1);
    pri_fault = 0; sec_fault = 1; cyc(1);
    ck_mode("R5", 3); ck_lock("R5", 0);

    // R7: manual release required
    sec_fault = 0; cyc(30); ck_mode("R7", 3);
    man_release = 1; cyc(2); ck_mode("R7", 1); ck_lock("R4", 0);
    cyc(SETTLE + 3); ck_lock("R4", 1);

    // R6: automatic return after GOOD fault-free cycles, restarted by a fault
    auto_ret_en = 1; sec_fault = 1; cyc(2); ck_mode("R6", 3);
    sec_fault = 0; cyc(GOOD - 4); sec_fault = 1; cyc(1); sec_fault = 0;
    cyc(GOOD - 3); ck_mode("R6", 3);
    cyc(5); ck_mode("R6", 1);
    cyc(SETTLE + 3); ck_lock("R6", 1);

    // R8: valid realign keeps lock high and lasts the hold time
    realign_pulse(LOWC + 5); cyc(3);
    ck_mode("R8", 4); ck_lock("R8", 1);
    cyc(HOLD - 6); ck_mode("R8", 4); ck_lock("R8", 1);
    cyc(6); ck_mode("R8", 1); ck_lock("R8", 1);

    // R9: short pulse ignored; full pulse in Holdover ignored
    realign_pulse(LOWC / 2); cyc(5); ck_mode("R9", 1);
    mode_req = 2'b01; cyc(6); ck_mode("R3", 2);
    realign_pulse(LOWC + 5); cyc(5); ck_mode("R9", 2);

    // R2: forced FreeRun from Auto Holdover
    mode_req = 2'b11; cyc(6); ck_mode("R3", 1);
    auto_ret_en = 0; sec_fault = 1; cyc(2); ck_mode("R5", 3);
    mode_req = 2'b10; cyc(5); ck_mode("R2", 0); ck_lock("R2", 0);
    sec_fault = 0;

    // Random mode / reference requests against the model
    for (int i = 0; i < 40; i++) begin
      logic [1:0] r;
      logic p;
      r = 2'($urandom % 4);
      p = 1'($urandom % 2);
      mode_req = r; ref_pick = p; cyc(6);
      ck_mode((r == 2'b10) ? "R2" : "R3", exp_mode(r));
      chk(ref_active == p, "R10", "ref_active", int'(ref_active), int'(p));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule